// File: doc/BRIEF.md
# Fixed-Window Video Bank Access Decoder

This block sits between a CPU load/store port and nine video memory banks of unequal size. The banks are packed back to back into one fixed address window for direct CPU access. For every request the block decides which bank, if any, the address hits, and works out the offset inside that bank. It then gates the access with a per-bank enable bitmap. Writes go out as a one-hot bank strobe with byte enables and lane-replicated data. Reads return the addressed byte, halfword or word one cycle later, zero-extended and aligned to bit 0.

The window repeats eight times, because the three address bits just above the bank field do not take part in the compare. An address that falls outside every bank, or inside a bank whose enable bit is clear, is treated as unmapped. Writes to it are dropped and reads of it return zero. The bank memories are outside the block and are expected to return read data one clock after they are selected. The enable bitmap is a plain input that some other logic holds steady.

Top module: `bank_window_decoder`

## Requirements
- R1: An address matches the window only when bits [31:23] equal 9'h00D. Bits [22:20] are ignored, so the same banks appear at eight mirrored copies.
- R2: Bits [19:14] form a 16 KiB slot number. Slots 0–31 select banks 0–3 (128 KiB each, eight slots per bank, in ascending order).
- R3: Slots 32–35 select bank 4 (64 KiB). Slot 36 selects bank 5 (16 KiB), slot 37 selects bank 6 (16 KiB), slots 38–39 select bank 7 (32 KiB) and slot 40 selects bank 8 (16 KiB). Slots 41–63 hit no bank.
- R4: `mem_offset` carries address bits [16:0] masked to the size of the selected bank: 17 bits for banks 0–3, 16 for bank 4, 15 for bank 7 and 14 for banks 5, 6 and 8. The bits above that width are zero.
- R5: An address that matches no bank raises no bank strobe. A read of it returns zero.
- R6: Bit i of `bank_en` enables bank i. An access to a bank whose bit is clear behaves exactly as unmapped (R5).
- R7: `mem_sel` is one-hot or zero. It is non-zero only while `req_valid` is high. `mem_we` is high only together with a bank strobe and `req_write`.
- R8: A valid read raises `rsp_valid` for exactly the next cycle, with the data the selected bank returned. A write never raises `rsp_valid`.
- R9: `req_size` encodes 0 = byte, 1 = halfword, 2 or 3 = word. `mem_be` is 4'b0001 shifted left by address bits [1:0] for a byte. For a halfword it is 4'b0011, or 4'b1100 when address bit 1 is set. For a word it is 4'b1111.
- R10: `mem_wdata` repeats the low byte of `req_wdata` in all four lanes for a byte access and the low halfword in both halves for a halfword access. A word passes through unchanged. Only the lanes flagged in `mem_be` change in memory.
- R11: Read data is shifted down from the lane the address names and zero-extended: 8 bits for a byte, 16 bits for a halfword, all 32 bits for a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 32 | CPU byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| bank_en | input | 9 | Per-bank access enable |
| mem_sel | output | 9 | One-hot bank strobe |
| mem_we | output | 1 | Write strobe for the selected bank |
| mem_offset | output | 17 | Byte offset inside the selected bank |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 288 | Read data of all banks, bank i at bits [32i+31:32i] |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Aligned, zero-extended read data |

## Verification
The bound checker watches, on every cycle, that the strobe stays one-hot and only follows a valid request. It also checks that no strobe reaches a disabled bank or an address outside the window tag, and that write byte enables always cover one, two or four lanes. It further checks that responses appear only one cycle after reads, and that a read which raised no strobe returns zero. Whether each slot lands in the right bank, whether offsets are masked to the right width and whether the mirrors alias correctly can only be shown by the bench's sweep against an arithmetic reference decode. The same holds for the lane steering of sub-word writes and reads.

// File: rtl/bwd_pkg.sv
// Package: bwd_pkg
// Shared constants, the access-size encoding and the bank layout of the
// direct-access window. The layout is expressed as first slot, slot count
// and offset width per bank, where a slot is one 16 KiB step of the window.
package bwd_pkg;

    localparam int NUM_BANKS = 9;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int LANES     = DATA_W / 8;
    localparam int LANE_W    = $clog2(LANES);
    localparam int OFF_W     = 17;
    localparam int SLOT_LSB  = 14;
    localparam int SLOT_W    = 6;
    localparam int TAG_LSB   = 23;
    localparam int TAG_W     = ADDR_W - TAG_LSB;
    localparam int BANK_W    = $clog2(NUM_BANKS);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } acc_size_e;

    // First 16 KiB slot occupied by bank b.
    function automatic int bank_first_slot(input int b);
        case (b)
            0: return 0;
            1: return 8;
            2: return 16;
            3: return 24;
            4: return 32;
            5: return 36;
            6: return 37;
            7: return 38;
            default: return 40;
        endcase
    endfunction

    // Number of 16 KiB slots occupied by bank b.
    function automatic int bank_slot_count(input int b);
        case (b)
            0, 1, 2, 3: return 8;
            4:          return 4;
            7:          return 2;
            default:    return 1;
        endcase
    endfunction

    // Width of the bank-local byte offset, derived from the slot count.
    function automatic int bank_off_width(input int b);
        return SLOT_LSB + $clog2(bank_slot_count(b));
    endfunction

    // Offset mask for bank b.
    function automatic logic [OFF_W-1:0] bank_off_mask(input int b);
        logic [OFF_W:0] one_hot;
        one_hot = '0;
        one_hot[bank_off_width(b)] = 1'b1;
        return OFF_W'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/bwd_window_decode.sv
// Module: bwd_window_decode
// Purely combinational window decode. Compares the address tag with the
// window tag (the mirror bits below the tag are ignored), finds which bank
// owns the 16 KiB slot and masks the low address to that bank's size.
// Assumes the bank layout in bwd_pkg is contiguous and non-overlapping.
module bwd_window_decode
    import bwd_pkg::*;
#(
    parameter logic [TAG_W-1:0] WIN_TAG = 9'h00D
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] hit_vec,
    output logic [OFF_W-1:0]     offset
);

    logic              tag_ok;
    logic [SLOT_W-1:0] slot;
    logic              unused_mirror;

    assign tag_ok        = (addr[ADDR_W-1:TAG_LSB] == WIN_TAG);
    assign slot          = addr[SLOT_LSB+SLOT_W-1:SLOT_LSB];
    assign unused_mirror = ^addr[TAG_LSB-1:SLOT_LSB+SLOT_W];

    // One range comparator per bank, built from the package layout.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int FIRST = bank_first_slot(b);
        localparam int LAST  = FIRST + bank_slot_count(b);
        assign hit_vec[b] = tag_ok
                          && (int'(slot) >= FIRST)
                          && (int'(slot) <  LAST);
    end

    // Mask the low address bits to the width of whichever bank matched.
    always_comb begin
        offset = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit_vec[b]) begin
                offset = offset | (addr[OFF_W-1:0] & bank_off_mask(b));
            end
        end
    end

endmodule

// File: rtl/bwd_lane_ctrl.sv
// Module: bwd_lane_ctrl
// Write-side lane steering. Builds byte enables from the access size and
// the low address bits, and replicates right-aligned write data into every
// lane it could occupy. Assumes halfword and word accesses are naturally
// aligned; the address bits below the access size are ignored.
module bwd_lane_ctrl
    import bwd_pkg::*;
(
    input  acc_size_e          size,
    input  logic [LANE_W-1:0]  lane,
    input  logic [DATA_W-1:0]  wdata_in,
    output logic [LANES-1:0]   be,
    output logic [DATA_W-1:0]  wdata_out
);

    // Select the enabled lanes for the requested size.
    always_comb begin
        case (size)
            SZ_BYTE: be = LANES'(1) << lane;
            SZ_HALF: be = lane[1] ? 4'b1100 : 4'b0011;
            default: be = '1;
        endcase
    end

    // Repeat the low byte or halfword across the data bus.
    always_comb begin
        case (size)
            SZ_BYTE: wdata_out = {LANES{wdata_in[7:0]}};
            SZ_HALF: wdata_out = {(LANES/2){wdata_in[15:0]}};
            default: wdata_out = wdata_in;
        endcase
    end

endmodule

// File: rtl/bwd_read_return.sv
// Module: bwd_read_return
// Read response stage. Captures which bank a read selected, together with
// its size and lane, then picks that bank's returned word one cycle later
// and aligns and zero-extends it. Assumes every bank returns read data
// exactly one cycle after it is strobed for a read.
module bwd_read_return
    import bwd_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_fire,
    input  logic [NUM_BANKS-1:0]        rd_sel,
    input  acc_size_e                   rd_size,
    input  logic [LANE_W-1:0]           rd_lane,
    input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
    output logic                        rsp_valid,
    output logic [DATA_W-1:0]           rsp_rdata
);

    logic [NUM_BANKS-1:0] sel_q;
    acc_size_e            size_q;
    logic [LANE_W-1:0]    lane_q;
    logic [DATA_W-1:0]    word;
    logic [DATA_W-1:0]    shifted;

    // Hold the context of a read for its response cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            sel_q     <= '0;
            size_q    <= SZ_WORD;
            lane_q    <= '0;
        end else begin
            rsp_valid <= rd_fire;
            sel_q     <= rd_fire ? rd_sel : '0;
            size_q    <= rd_size;
            lane_q    <= rd_lane;
        end
    end

    // Pick the returned word of the bank that was strobed; zero if none.
    always_comb begin
        word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel_q[b]) begin
                word = word | bank_rdata[b*DATA_W +: DATA_W];
            end
        end
    end

    // Move the addressed lane down to bit 0 and clear the rest.
    always_comb begin
        shifted = word >> (8 * int'(lane_q));
        case (size_q)
            SZ_BYTE: rsp_rdata = {{(DATA_W-8){1'b0}}, shifted[7:0]};
            SZ_HALF: rsp_rdata = {{(DATA_W-16){1'b0}},
                                  (lane_q[1] ? word[31:16] : word[15:0])};
            default: rsp_rdata = word;
        endcase
    end

endmodule

// File: rtl/bank_window_decoder.sv
// Module: bank_window_decoder
// Top of the direct-access decoder. Decodes the request address into one
// of the banks, gates it with the enable bitmap and the request valid,
// drives the bank strobe, offset, byte enables and write data, and
// returns aligned read data one cycle later. Assumes bank_en is held
// steady by its owner and that bank memories have one cycle read latency.
module bank_window_decoder
    import bwd_pkg::*;
#(
    parameter logic [TAG_W-1:0] WIN_TAG = 9'h00D
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [1:0]                  req_size,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [DATA_W-1:0]           req_wdata,
    input  logic [NUM_BANKS-1:0]        bank_en,
    output logic [NUM_BANKS-1:0]        mem_sel,
    output logic                        mem_we,
    output logic [OFF_W-1:0]            mem_offset,
    output logic [LANES-1:0]            mem_be,
    output logic [DATA_W-1:0]           mem_wdata,
    input  logic [NUM_BANKS*DATA_W-1:0] mem_rdata,
    output logic                        rsp_valid,
    output logic [DATA_W-1:0]           rsp_rdata
);

    logic [NUM_BANKS-1:0] hit_vec;
    logic [OFF_W-1:0]     dec_offset;
    acc_size_e            size;
    logic                 rd_fire;

    assign size = acc_size_e'(req_size);

    bwd_window_decode #(
        .WIN_TAG (WIN_TAG)
    ) u_decode (
        .addr    (req_addr),
        .hit_vec (hit_vec),
        .offset  (dec_offset)
    );

    // Strobe only an enabled, matched bank while a request is present.
    always_comb begin
        mem_sel    = req_valid ? (hit_vec & bank_en) : '0;
        mem_we     = req_write && (mem_sel != '0);
        mem_offset = (mem_sel != '0) ? dec_offset : '0;
    end

    bwd_lane_ctrl u_lanes (
        .size      (size),
        .lane      (req_addr[LANE_W-1:0]),
        .wdata_in  (req_wdata),
        .be        (mem_be),
        .wdata_out (mem_wdata)
    );

    // Every valid read gets a response, mapped or not.
    assign rd_fire = req_valid && !req_write;

    bwd_read_return u_return (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_fire    (rd_fire),
        .rd_sel     (mem_sel),
        .rd_size    (size),
        .rd_lane    (req_addr[LANE_W-1:0]),
        .bank_rdata (mem_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

endmodule

// File: rtl/bank_window_decoder_chk.sv
// Module: bank_window_decoder_chk
// Cycle-by-cycle properties of the decoder's port behaviour, bound to
// the top module.
module bank_window_decoder_chk
    import bwd_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [NUM_BANKS-1:0] bank_en,
    input logic [NUM_BANKS-1:0] mem_sel,
    input logic                 mem_we,
    input logic [LANES-1:0]     mem_be,
    input logic                 rsp_valid,
    input logic [DATA_W-1:0]    rsp_rdata
);

    assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_sel));

    assert_sel_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel != '0) |-> req_valid);

    assert_we_needs_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (req_write && (mem_sel != '0)));

    assert_sel_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel != '0) |-> (req_addr[ADDR_W-1:TAG_LSB] == 9'h00D));

    assert_sel_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel & ~bank_en) == '0);

    assert_be_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                    || $countones(mem_be) == 4));

    assert_rsp_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    assert_no_rsp_otherwise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && mem_sel == '0) |=> (rsp_rdata == '0));

endmodule

bind bank_window_decoder bank_window_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .bank_en   (bank_en),
    .mem_sel   (mem_sel),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
);

// File: tb/bank_window_decoder_tb.sv
`timescale 1ns/1ps
module bank_window_decoder_tb;

    localparam int NB = 9;
    localparam int RW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'd2;
    logic [31:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [NB-1:0] bank_en = '1;
    logic [NB-1:0] mem_sel;
    logic          mem_we;
    logic [16:0]   mem_offset;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata;
    logic [NB*32-1:0] mem_rdata;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;

    int total = 0;
    int bad   = 0;

    logic [31:0] ram   [NB][RW];
    logic [31:0] model [NB][RW];
    logic [31:0] rd_q  [NB];

    always #2 clk = ~clk;

    bank_window_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .bank_en(bank_en), .mem_sel(mem_sel), .mem_we(mem_we),
        .mem_offset(mem_offset), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // Small bank memories with one cycle read latency.
    always @(posedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (mem_sel[b]) begin
                if (mem_we) begin
                    for (int l = 0; l < 4; l++)
                        if (mem_be[l]) ram[b][mem_offset[7:2]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
                end else begin
                    rd_q[b] <= ram[b][mem_offset[7:2]];
                end
            end
        end
    end

    always_comb
        for (int b = 0; b < NB; b++) mem_rdata[b*32 +: 32] = rd_q[b];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, req_addr, act, exp);
        end
    endtask

    // Arithmetic reference decode: bank index (-1 for none) and offset.
    function automatic void ref_decode(input logic [31:0] a, output int bank, output logic [16:0] off);
        int rel;
        bank = -1; off = '0;
        if (a[31:23] != 9'h00D) return;
        rel = int'(a[19:0]);
        if (rel < 'h80000)      begin bank = rel / 'h20000; off = 17'(rel % 'h20000); end
        else if (rel < 'h90000) begin bank = 4; off = 17'(rel % 'h10000); end
        else if (rel < 'h94000) begin bank = 5; off = 17'(rel % 'h4000); end
        else if (rel < 'h98000) begin bank = 6; off = 17'(rel % 'h4000); end
        else if (rel < 'hA0000) begin bank = 7; off = 17'(rel % 'h8000); end
        else if (rel < 'hA4000) begin bank = 8; off = 17'(rel % 'h4000); end
    endfunction

    function automatic logic [3:0] ref_be(input logic [1:0] sz, input logic [1:0] lo);
        if (sz == 2'd0) return 4'(1 << lo);
        if (sz == 2'd1) return lo[1] ? 4'hC : 4'h3;
        return 4'hF;
    endfunction

    function automatic logic [31:0] ref_extract(input logic [31:0] w, input logic [1:0] sz, input logic [1:0] lo);
        if (sz == 2'd0) return (w >> (8*lo)) & 32'hFF;
        if (sz == 2'd1) return (w >> (lo[1] ? 16 : 0)) & 32'hFFFF;
        return w;
    endfunction

    // One request: decode checks before the edge, response check after it.
    task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                          input logic [31:0] wd, input logic chk_dec);
        int bank; logic [16:0] off; logic [NB-1:0] esel; logic [3:0] be;
        logic [31:0] rep, exp_rd;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        ref_decode(a, bank, off);
        if (bank >= 0 && !bank_en[bank]) bank = -1;
        esel = (bank >= 0) ? NB'(1 << bank) : '0;
        #1;
        if (chk_dec) begin
            check("R2/R3 select", 64'(mem_sel), 64'(esel));
            if (bank >= 0) check("R4 offset", 64'(mem_offset), 64'(off));
            check("R7 write strobe", 64'(mem_we), 64'(wr && bank >= 0));
        end
        be = ref_be(sz, a[1:0]);
        rep = (sz == 2'd0) ? {4{wd[7:0]}} : (sz == 2'd1) ? {2{wd[15:0]}} : wd;
        exp_rd = 32'h0;
        if (bank >= 0) begin
            if (wr) begin
                check("R9 byte enables", 64'(mem_be), 64'(be));
                for (int l = 0; l < 4; l++)
                    if (be[l]) model[bank][off[7:2]][l*8 +: 8] = rep[l*8 +: 8];
            end else begin
                exp_rd = ref_extract(model[bank][off[7:2]], sz, a[1:0]);
            end
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        #1;
        check(wr ? "R8 no response on write" : "R8 response valid", 64'(rsp_valid), 64'(!wr));
        if (!wr) check(bank >= 0 ? "R11 read data" : "R5 unmapped reads zero",
                       64'(rsp_rdata), 64'(exp_rd));
    endtask

    function automatic logic [31:0] bank_base(input int b);
        int slots [NB] = '{0, 8, 16, 24, 32, 36, 37, 38, 40};
        return 32'h0680_0000 + 32'(slots[b]) * 32'h4000;
    endfunction

    initial begin
        #800000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            rd_q[b] = '0;
            for (int w = 0; w < RW; w++) begin
                ram[b][w] = '0; model[b][w] = '0;
            end
        end
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset response", 64'(rsp_valid), 64'(0));
        check("R7 reset select", 64'(mem_sel), 64'(0));
        @(negedge clk); rst_n = 1'b1;

        // R1 R2 R3 R4: every slot, every mirror, three offsets per slot.
        for (int m = 0; m < 8; m++)
            for (int s = 0; s < 64; s++)
                for (int k = 0; k < 3; k++) begin
                    logic [13:0] lo = (k == 0) ? 14'h0 : (k == 1) ? 14'h2A6C : 14'h3FFC;
                    access(1'b0, 2'd2, {9'h00D, 3'(m), 6'(s), lo}, 32'h0, 1'b1);
                end

        // R1 R5: tags outside the window never select a bank.
        foreach (bank_en[i]) begin
            access(1'b0, 2'd2, {9'h00C, 3'd0, 6'(i * 4), 14'h10}, 32'h0, 1'b1);
            access(1'b1, 2'd2, {9'h10D, 3'd0, 6'(i * 4), 14'h10}, 32'h5A5A5A5A, 1'b1);
        end

        // R6: each bank disabled alone, then enabled alone.
        for (int b = 0; b < NB; b++) begin
            bank_en = ~NB'(1 << b);
            access(1'b1, 2'd2, bank_base(b) + 32'h40, 32'hDEAD0000 | 32'(b), 1'b1);
            access(1'b0, 2'd2, bank_base(b) + 32'h40, 32'h0, 1'b1);
            bank_en = NB'(1 << b);
            access(1'b0, 2'd2, bank_base(b) + 32'h40, 32'h0, 1'b1);
            access(1'b0, 2'd2, bank_base((b + 1) % NB) + 32'h40, 32'h0, 1'b1);
        end
        bank_en = '1;

        // R9 R10 R11: word, byte and halfword writes and reads in every bank.
        for (int b = 0; b < NB; b++) begin
            logic [31:0] a = bank_base(b) + 32'h80 + 32'(b * 4);
            access(1'b1, 2'd2, a, 32'h1122_3344 ^ 32'(b << 24), 1'b1);
            for (int l = 0; l < 4; l++) begin
                access(1'b1, 2'd0, a + 32'(l), 32'hFFFF_FF00 | 32'(8'hA0 + l + b), 1'b1);
                access(1'b0, 2'd0, a + 32'(l), 32'h0, 1'b1);
            end
            access(1'b1, 2'd1, a + 32'd2, 32'h0000_BEEF + 32'(b), 1'b1);
            access(1'b0, 2'd1, a, 32'h0, 1'b1);
            access(1'b0, 2'd1, a + 32'd2, 32'h0, 1'b1);
            access(1'b0, 2'd3, a, 32'h0, 1'b1);
            access(1'b1, 2'd1, a + 32'd0, 32'h0000_C0DE, 1'b1);
            access(1'b0, 2'd2, a + 32'h0070_0000, 32'h0, 1'b1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule